// File: doc/BRIEF.md
# General-Purpose Pin Controller with Event Detection

This block drives and samples 64 general-purpose pins through a small word-addressed register file. The pins form two banks of 32. Each pin has an output value, a drive-enable (direction) bit and a function-select bit. When the select bit is set, the pad output and its drive enable come from an alternate peripheral instead of the registers. All pad inputs pass through a two-stage synchronizer before software or the detection logic sees them.

The lowest 16 pins can raise interrupts. Each of these pins has three trigger bits, one in each of three registers: edge, high and low. Together they select level-low, level-high, either-level, rising, falling or both-edge detection, or no detection. A detected condition sets a pending flag. The flags are gated by an enable mask, ORed together and registered to give a single interrupt line.

A pending flag is cleared by a clear register that holds its value. While a clear bit is 1, the matching flag is forced to 0 and stays at 0. Software writes 1 and then 0 to release it.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, these registers read zero: output, direction, select, edge, high, low, clear, enable and pending. The interrupt output is 0 and no pad is driven (pad_oe all zero).
- R2: Registers sit at byte offsets on word boundaries:
  - 0x00 and 0x04: input banks (read-only).
  - 0x08 and 0x0C: output banks.
  - 0x10 and 0x14: direction banks.
  - 0x18 and 0x1C: select banks.
  - 0x20: edge. 0x24: high. 0x28: low. 0x2C: clear. 0x30: enable.
  - 0x34: pending (read-only).
  The first bank holds pins 0-31 and the second holds pins 32-63. The 16-bit registers read with bits 31:16 zero. Writes to read-only or unmapped offsets have no effect, and unmapped offsets read zero.
- R3: Pad muxing works per pin. With select 0, pad_out follows the output bit and pad_oe follows the direction bit (1 = output). With select 1, pad_out and pad_oe follow alt_out and alt_oe.
- R4: A pad input change shows in the input register two clock edges after it is applied, and not after one.
- R5: With edge bit 0, the pending flag tracks the synchronized level:
  - {edge,high,low} = 001 is active while the pin is low.
  - 010 is active while the pin is high.
  - 011 is always active.
  - 000 never sets the flag.
  The flag changes three edges after the pad changes.
- R6: With edge bit 1, the pending flag is sticky:
  - 110 sets it on a rising edge.
  - 101 sets it on a falling edge.
  - 111 sets it on either edge.
  - 100 never sets it.
  The flag is set three edges after the pad changes.
- R7: While a clear bit is 1, the pending flag is 0 one edge later and stays 0 regardless of pin activity. After the bit returns to 0, the next qualifying event sets the flag again.
- R8: irq is 1 exactly when, one edge earlier, some pin had both its pending bit and its enable bit set.
- R9: Pins 16-63 never produce pending flags, even when every configuration bit is written with ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr (combinational) |
| pad_in | input | 64 | Raw pad input values |
| pad_out | output | 64 | Pad output values |
| pad_oe | output | 64 | Pad drive enables |
| alt_out | input | 64 | Alternate-function output values |
| alt_oe | input | 64 | Alternate-function drive enables |
| irq | output | 1 | Combined registered interrupt |

## Verification
The hardest situation to reach from the ports is a sticky edge flag that keeps receiving events while its clear bit is held high, followed by a clean re-arm after release. A directed sequence holds the clear bit, toggles the pin through several rising edges, releases the clear and then produces one more edge.

Long random runs rewrite the trigger bits mid-activity and toggle the pads sparsely. This covers edge-to-level mode switches and the transient trigger codes that arise while the three bit registers are updated one after another. A bench model predicts the pending vector, irq and pad outputs every cycle.

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl #(
  parameter int BANK_W = 32,
  parameter int NIRQ   = 16,
  parameter int AW     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic                wr_en,
  input  logic [BANK_W-1:0]   wr_data,
  output logic [BANK_W-1:0]   rd_data,
  input  logic [2*BANK_W-1:0] pad_in,
  output logic [2*BANK_W-1:0] pad_out,
  output logic [2*BANK_W-1:0] pad_oe,
  input  logic [2*BANK_W-1:0] alt_out,
  input  logic [2*BANK_W-1:0] alt_oe,
  output logic                irq
);
  localparam int NPINS = 2 * BANK_W;
  localparam int PADW  = BANK_W - NIRQ;

  logic [NPINS-1:0] out_q, dir_q, sel_q, sync1_q, sync2_q;
  logic [NIRQ-1:0]  prev_q, edge_q, hi_q, lo_q, clr_q, en_q, pend_q;
  logic [NIRQ-1:0]  lvl, rise, fall, edge_hit, lvl_hit, pend_d;
  logic             irq_q;
  logic             aligned;
  int unsigned      widx;

  assign aligned = (addr[1:0] == 2'b00);
  assign widx    = int'(addr[AW-1:2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      sel_q  <= '0;
      edge_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      clr_q  <= '0;
      en_q   <= '0;
    end else if (wr_en && aligned) begin
      case (widx)
        2:  out_q[BANK_W-1:0]     <= wr_data;
        3:  out_q[NPINS-1:BANK_W] <= wr_data;
        4:  dir_q[BANK_W-1:0]     <= wr_data;
        5:  dir_q[NPINS-1:BANK_W] <= wr_data;
        6:  sel_q[BANK_W-1:0]     <= wr_data;
        7:  sel_q[NPINS-1:BANK_W] <= wr_data;
        8:  edge_q <= wr_data[NIRQ-1:0];
        9:  hi_q   <= wr_data[NIRQ-1:0];
        10: lo_q   <= wr_data[NIRQ-1:0];
        11: clr_q  <= wr_data[NIRQ-1:0];
        12: en_q   <= wr_data[NIRQ-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q[NIRQ-1:0];
    end
  end

  assign lvl      = sync2_q[NIRQ-1:0];
  assign rise     = lvl & ~prev_q;
  assign fall     = ~lvl & prev_q;
  assign edge_hit = (hi_q & rise) | (lo_q & fall);
  assign lvl_hit  = (hi_q & lvl) | (lo_q & ~lvl);
  assign pend_d   = ~clr_q & ((edge_q & (pend_q | edge_hit)) | (~edge_q & lvl_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= |(pend_q & en_q);
    end
  end

  assign irq     = irq_q;
  assign pad_out = (sel_q & alt_out) | (~sel_q & out_q);
  assign pad_oe  = (sel_q & alt_oe)  | (~sel_q & dir_q);

  always_comb begin
    rd_data = '0;
    if (aligned) begin
      case (widx)
        0:  rd_data = sync2_q[BANK_W-1:0];
        1:  rd_data = sync2_q[NPINS-1:BANK_W];
        2:  rd_data = out_q[BANK_W-1:0];
        3:  rd_data = out_q[NPINS-1:BANK_W];
        4:  rd_data = dir_q[BANK_W-1:0];
        5:  rd_data = dir_q[NPINS-1:BANK_W];
        6:  rd_data = sel_q[BANK_W-1:0];
        7:  rd_data = sel_q[NPINS-1:BANK_W];
        8:  rd_data = {{PADW{1'b0}}, edge_q};
        9:  rd_data = {{PADW{1'b0}}, hi_q};
        10: rd_data = {{PADW{1'b0}}, lo_q};
        11: rd_data = {{PADW{1'b0}}, clr_q};
        12: rd_data = {{PADW{1'b0}}, en_q};
        13: rd_data = {{PADW{1'b0}}, pend_q};
        default: rd_data = '0;
      endcase
    end
  end
endmodule

module gpio_irq_ctrl_chk #(
  parameter int BANK_W = 32,
  parameter int NIRQ   = 16,
  parameter int AW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     addr,
  input logic [BANK_W-1:0] rd_data,
  input logic              irq,
  input logic [NIRQ-1:0]   pend_q,
  input logic [NIRQ-1:0]   edge_q,
  input logic [NIRQ-1:0]   hi_q,
  input logic [NIRQ-1:0]   lo_q,
  input logic [NIRQ-1:0]   clr_q,
  input logic [NIRQ-1:0]   en_q
);
  p_no_enable_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq);

  p_clear_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q != '0) |=> ((pend_q & $past(clr_q)) == '0));

  p_edge_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & $past(pend_q & edge_q & ~clr_q)) == $past(pend_q & edge_q & ~clr_q)));

  p_mode_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(~edge_q & ~hi_q & ~lo_q)) == '0);

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(8'h34)) |-> (rd_data[BANK_W-1:NIRQ] == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.BANK_W(BANK_W), .NIRQ(NIRQ), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_data(rd_data), .irq(irq),
  .pend_q(pend_q), .edge_q(edge_q), .hi_q(hi_q), .lo_q(lo_q),
  .clr_q(clr_q), .en_q(en_q)
);

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [63:0] pad_in = '0, pad_out, pad_oe, alt_out = '0, alt_oe = '0;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
  );

  logic [63:0] m_out, m_dir, m_sel, m_s1, m_s2;
  logic [15:0] m_prev, m_edge, m_hi, m_lo, m_clr, m_en, m_pend;
  logic        m_irq;

  function automatic logic next_pend(logic e, logic h, logic l, logic c,
                                     logic old, logic s, logic p);
    if (c) return 1'b0;
    if (e) return old | (h & s & ~p) | (l & ~s & p);
    return (h & s) | (l & ~s);
  endfunction

  function automatic logic [63:0] mux_exp(logic [63:0] sel, logic [63:0] a, logic [63:0] b);
    return (sel & a) | (~sel & b);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out <= '0; m_dir <= '0; m_sel <= '0; m_s1 <= '0; m_s2 <= '0;
      m_prev <= '0; m_edge <= '0; m_hi <= '0; m_lo <= '0; m_clr <= '0;
      m_en <= '0; m_pend <= '0; m_irq <= 1'b0;
    end else begin
      m_s1 <= pad_in;
      m_s2 <= m_s1;
      m_prev <= m_s2[15:0];
      for (int i = 0; i < 16; i++)
        m_pend[i] <= next_pend(m_edge[i], m_hi[i], m_lo[i], m_clr[i], m_pend[i], m_s2[i], m_prev[i]);
      m_irq <= |(m_pend & m_en);
      if (wr_en && addr[1:0] == 2'b00) begin
        case (addr)
          8'h08: m_out[31:0]  <= wr_data;
          8'h0C: m_out[63:32] <= wr_data;
          8'h10: m_dir[31:0]  <= wr_data;
          8'h14: m_dir[63:32] <= wr_data;
          8'h18: m_sel[31:0]  <= wr_data;
          8'h1C: m_sel[63:32] <= wr_data;
          8'h20: m_edge <= wr_data[15:0];
          8'h24: m_hi   <= wr_data[15:0];
          8'h28: m_lo   <= wr_data[15:0];
          8'h2C: m_clr  <= wr_data[15:0];
          8'h30: m_en   <= wr_data[15:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog: actual hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 8; a <= 8'h34; a += 4) begin
      rd(8'(a), v);
      chk($sformatf("R1 reset reg %02h", a), {32'h0, v}, 64'h0);
    end
    chk("R1 reset irq", {63'h0, irq}, 64'h0);
    chk("R1 reset pad_oe", pad_oe, 64'h0);

    // R2 map, widths, read-only and unmapped
    @(negedge clk);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); chk("R2 edge width", {32'h0, v}, 64'h0000_FFFF);
    wr(8'h20, 32'h0);
    wr(8'h0C, 32'hA5A5_5A5A);
    rd(8'h0C, v); chk("R2 out bank1", {32'h0, v}, 64'hA5A5_5A5A);
    rd(8'h08, v); chk("R2 out bank0 untouched", {32'h0, v}, 64'h0);
    pad_in = 64'h1234_0000_0000_0000;
    repeat (3) @(negedge clk);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R2 input read-only", {32'h0, v}, 64'h1234_0000);
    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h34, v); chk("R2 pending read-only", {32'h0, v}, 64'h0);
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, v); chk("R2 unmapped", {32'h0, v}, 64'h0);

    // R4 synchronizer latency
    rd(8'h04, v);
    pad_in[40] = 1'b1;
    @(negedge clk); rd(8'h04, v);
    chk("R4 one edge old", {32'h0, v}, 64'h1234_0000);
    @(negedge clk); rd(8'h04, v);
    chk("R4 two edges new", {32'h0, v}, 64'h1234_0100);

    // R3 pad muxing
    alt_out = 64'hF0F0_F0F0_0F0F_0F0F;
    alt_oe  = 64'h3333_3333_CCCC_CCCC;
    wr(8'h10, 32'h0000_FFFF);
    wr(8'h08, 32'h1234_5678);
    wr(8'h18, 32'h00FF_00F0);
    wr(8'h1C, 32'hFFFF_0000);
    #1;
    chk("R3 pad_out", pad_out, mux_exp(64'hFFFF_0000_00FF_00F0, alt_out, 64'hA5A5_5A5A_1234_5678));
    chk("R3 pad_oe", pad_oe, mux_exp(64'hFFFF_0000_00FF_00F0, alt_oe, 64'h0000_0000_0000_FFFF));

    // R6 rising edge, sticky
    wr(8'h20, 32'h0000_0008);
    wr(8'h24, 32'h0000_0008);
    pad_in[3] = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'h34, v); chk("R6 rise before latency", {32'h0, v}, 64'h0);
    @(negedge clk);
    rd(8'h34, v); chk("R6 rise after 3 edges", {32'h0, v}, 64'h8);
    pad_in[3] = 1'b0;
    repeat (4) @(negedge clk);
    rd(8'h34, v); chk("R6 sticky after fall", {32'h0, v}, 64'h8);

    // R8 interrupt output
    wr(8'h30, 32'h0000_0008);
    chk("R8 irq not yet", {63'h0, irq}, 64'h0);
    @(negedge clk);
    chk("R8 irq raised", {63'h0, irq}, 64'h1);

    // R7 held clear
    wr(8'h2C, 32'h0000_0008);
    @(negedge clk);
    rd(8'h34, v); chk("R7 cleared", {32'h0, v}, 64'h0);
    for (int k = 0; k < 6; k++) begin
      pad_in[3] = ~pad_in[3];
      repeat (2) @(negedge clk);
    end
    pad_in[3] = 1'b0;
    repeat (4) @(negedge clk);
    rd(8'h34, v); chk("R7 held through edges", {32'h0, v}, 64'h0);
    chk("R8 irq dropped", {63'h0, irq}, 64'h0);
    wr(8'h2C, 32'h0);
    repeat (3) @(negedge clk);
    rd(8'h34, v); chk("R7 released no event", {32'h0, v}, 64'h0);
    pad_in[3] = 1'b1;
    repeat (3) @(negedge clk);
    rd(8'h34, v); chk("R7 re-armed", {32'h0, v}, 64'h8);

    // R6 falling mode on pin 4 (101)
    wr(8'h20, 32'h0000_0018);
    wr(8'h28, 32'h0000_0010);
    pad_in[4] = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h34, v); chk("R6 fall mode ignores rise", {32'h0, v & 32'h10}, 64'h0);
    pad_in[4] = 1'b0;
    repeat (3) @(negedge clk);
    rd(8'h34, v); chk("R6 fall detected", {32'h0, v & 32'h10}, 64'h10);

    // R5 level-low on pin 5, then either-level
    wr(8'h28, 32'h0000_0030);
    repeat (2) @(negedge clk);
    rd(8'h34, v); chk("R5 level low active", {32'h0, v & 32'h20}, 64'h20);
    pad_in[5] = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'h34, v); chk("R5 level latency", {32'h0, v & 32'h20}, 64'h20);
    @(negedge clk);
    rd(8'h34, v); chk("R5 level follows high pin", {32'h0, v & 32'h20}, 64'h0);
    wr(8'h24, 32'h0000_0028);
    @(negedge clk);
    rd(8'h34, v); chk("R5 either level", {32'h0, v & 32'h20}, 64'h20);

    // R9 upper pins never pend
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    for (int k = 0; k < 6; k++) begin
      pad_in[63:16] = ~pad_in[63:16];
      repeat (2) @(negedge clk);
      rd(8'h34, v); chk("R9 upper pins quiet", {32'h0, v & 32'hFFFF_0000}, 64'h0);
    end

    // random phase against bench model
    rst_n = 1'b0;
    pad_in = '0;
    @(negedge clk);
    rst_n = 1'b1;
    addr = 8'h34;
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk); #1;
      if (!wr_en) chk("R5 R6 R7 random pending", {32'h0, rd_data}, {48'h0, m_pend});
      chk("R8 random irq", {63'h0, irq}, {63'h0, m_irq});
      chk("R3 random pad_out", pad_out, mux_exp(m_sel, alt_out, m_out));
      chk("R3 random pad_oe", pad_oe, mux_exp(m_sel, alt_oe, m_dir));
      pad_in = pad_in ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      alt_out = {$urandom, $urandom};
      alt_oe  = {$urandom, $urandom};
      if ($urandom % 6 == 0) begin
        wr_en = 1'b1;
        addr = 8'(8 + 4 * ($urandom % 11));
        wr_data = (addr == 8'h2C) ? ($urandom & $urandom & $urandom) : $urandom;
      end else begin
        wr_en = 1'b0;
        addr = 8'h34;
      end
    end
    done = 1;
    summary();
    $finish;
  end
endmodule